// File: doc/BRIEF.md
# Table-Access Mailbox Responder

This block serves read requests for a small, fixed table of device attributes. Each request arrives as a data object over a mailbox. A requester writes the request one 32-bit word at a time into a write mailbox, then pulses a go strobe. The block checks the request and looks up the entry it names in an internal entry ROM. If the request passes the checks, the block assembles a response object in a read mailbox, one dword per cycle. The response holds an object header, a response word and the raw bytes of the entry. The response word carries the handle of the following entry, so a requester can walk the whole table with successive requests. It stops when it sees the terminal handle.

The requester pops the read mailbox one dword at a time, using a ready flag and an advance strobe. A configuration-read path gives precedence to the mailbox registers: when the read address selects one of them, the mailbox data is returned in place of a caller-supplied default word. Entry contents are computed from parameters. Entry h is 3 + 5h bytes long, and byte p of entry h is (32h + p + 1) mod 256.

Top module: `doe_table_responder`

## Requirements
- R1: A request whose length field (request dword 1, bits [17:0], counted in dwords) is below 3 is dropped and produces no response; the ready flag stays low.
- R2: Response dword 0 carries vendor ID 0x1D2E in bits [15:0] and object type 0x02 in bits [23:16], and is zero in bits [31:24].
- R3: Response dword 1 equals 3 plus the entry length in bytes divided by four and rounded up, with its upper 14 bits zero.
- R4: In response dword 2, bits [7:0] hold the response code 0x81 and bits [15:8] hold the table type 0x05. Bits [31:16] hold the requested handle plus one, or 0xFFFF when the requested entry is the last one (handle 3).
- R5: The entry bytes start at response dword 3, packed little-endian (byte p in dword 3 + p/4, lane p mod 4). Unused upper lanes of the final dword are zero.
- R6: While the ready flag is high, the read port shows the oldest unread dword, and each advance strobe pops one dword. The flag drops once the last dword is popped. The read port shows zero while the flag is low.
- R7: A response built while earlier words are still unread is appended behind them. The readable length grows by the new response's length field, and the older words are not disturbed.
- R8: The entry handle is bits [31:16] of request dword 2. A handle of 4 or more, or a go strobe with fewer than 3 request dwords written, is dropped. Every go strobe empties the write mailbox.
- R9: A configuration read at byte address 0x18C returns the current read-port word. A read at 0x184 returns the ready flag in bit 31 and zero elsewhere. Any other address returns the default input word.
- R10: A synchronous active-low reset empties both mailboxes and clears the readable length and the ready flag.
- R11: A response that would not fit in the 16-dword read mailbox next to the unread words is dropped whole, and the unread words stay intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr_en | input | 1 | Write one request dword |
| req_wr_data | input | 32 | Request dword |
| req_go | input | 1 | Start processing the collected request |
| rsp_rd_adv | input | 1 | Pop the current response dword |
| rsp_rd_data | output | 32 | Oldest unread response dword, zero when empty |
| rsp_ready | output | 1 | Read mailbox holds unread dwords |
| cfg_rd_addr | input | 12 | Configuration read byte address |
| cfg_dflt_data | input | 32 | Word from the default register read path |
| cfg_rd_data | output | 32 | Configuration read result |

## Verification
The hardest state to reach from the ports is a read mailbox that is full enough that the next response no longer fits (R11). Reaching it means stacking responses without popping any of them. The bench requests the largest entry three times in a row without reading. That fills exactly 16 dwords with the first two responses and forces the third to be dropped. It then drains the mailbox and checks that both stored copies are intact and that the flag falls after the last one. Appending behind unread data (R7) is reached the same way with two different entries, which also shows that each appended response begins at the right offset.

// File: rtl/doe_tbl_pkg.sv
// Package: shared widths, request/response layout constants and the
// response-builder state type for the table-access mailbox responder.
// Assumes dword-wide mailboxes and a 16-bit entry handle.
package doe_tbl_pkg;

    localparam int DW         = 32;   // mailbox word width
    localparam int HDL_W      = 16;   // entry handle width
    localparam int LEN_W      = 18;   // object length field width (dwords)
    localparam int REQ_DW     = 3;    // request object size in dwords
    localparam int RSP_HDR_DW = 3;    // response words ahead of entry bytes

    localparam logic [HDL_W-1:0] HDL_END = '1;  // terminal next-handle

    typedef enum logic [1:0] {
        B_IDLE,
        B_CHECK,
        B_EMIT
    } bld_state_t;

    // Number of dwords needed to hold nbytes bytes.
    function automatic int dw_ceil(input int nbytes);
        return (nbytes + 3) / 4;
    endfunction

endpackage

// File: rtl/doe_req_mbox.sv
// Request write mailbox: collects the first REQ_DW dwords of a request
// in arrival order and keeps a saturating word count. Later words are
// ignored. A clear empties it.
// Assumes the builder raises clr once per go strobe, after it has
// sampled the stored words.
module doe_req_mbox
    import doe_tbl_pkg::*;
#(
    parameter int CNT_W = $clog2(REQ_DW + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    input  logic                     clr,
    output logic [REQ_DW-1:0][DW-1:0] words,
    output logic [CNT_W-1:0]         cnt
);

    // Store incoming words until full; clear or reset empties the mailbox.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            words <= '0;
        end else if (clr) begin
            cnt   <= '0;
            words <= '0;
        end else if (wr_en && (cnt < CNT_W'(REQ_DW))) begin
            words[cnt] <= wr_data;
            cnt        <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/doe_entry_rom.sv
// Entry ROM: computes the attribute table from parameters. Entry i is
// LEN_BASE + LEN_STEP*i bytes long; byte p of entry i is (32*i+p+1)
// mod 256. Returns the entry length and one little-endian dword of the
// entry, with lanes past the end forced to zero.
// Assumes ent_idx < NUM_ENT (the caller checks the handle).
module doe_entry_rom
    import doe_tbl_pkg::*;
#(
    parameter int NUM_ENT  = 4,
    parameter int LEN_BASE = 3,
    parameter int LEN_STEP = 5,
    parameter int IDX_W    = 2,
    parameter int EDW_W    = 3,
    parameter int BYTE_W   = 5
) (
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic [EDW_W-1:0]  dw_idx,
    output logic [BYTE_W-1:0] ent_bytes,
    output logic [DW-1:0]     ent_dw
);

    // Length of the selected entry in bytes.
    always_comb begin
        ent_bytes = BYTE_W'(LEN_BASE + LEN_STEP * int'(ent_idx));
    end

    for (genvar b = 0; b < 4; b++) begin : g_lane
        int         pos;
        logic [7:0] lane;

        // One byte lane: the entry byte, or zero beyond the entry end.
        always_comb begin
            pos = 4 * int'(dw_idx) + b;
            if (pos < int'(ent_bytes)) begin
                lane = 8'(32 * int'(ent_idx) + pos + 1);
            end else begin
                lane = 8'h00;
            end
        end

        assign ent_dw[8*b +: 8] = lane;
    end

endmodule

// File: rtl/doe_rsp_builder.sv
// Response builder: on go, checks the collected request (word count,
// length field, handle range, room in the read mailbox). It then writes
// the response object into the read mailbox one dword per cycle and
// commits the new readable length on the last dword. A rejected request
// is dropped silently. Go is ignored while a build is in progress.
// Assumes valid_len does not move while the builder is busy, except
// by this builder's own commit.
module doe_rsp_builder
    import doe_tbl_pkg::*;
#(
    parameter int          NUM_ENT   = 4,
    parameter int          RD_DEPTH  = 16,
    parameter logic [15:0] VENDOR_ID = 16'h1D2E,
    parameter logic [7:0]  OBJ_TYPE  = 8'h02,
    parameter logic [7:0]  RSP_CODE  = 8'h81,
    parameter logic [7:0]  TBL_TYPE  = 8'h05,
    parameter int          IDX_W     = 2,
    parameter int          EDW_W     = 3,
    parameter int          BYTE_W    = 5,
    parameter int          RSP_W     = 4,
    parameter int          RIDX_W    = 5,
    parameter int          CNT_W     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic [REQ_DW-1:0][DW-1:0] req_words,
    input  logic [CNT_W-1:0]          req_cnt,
    input  logic [RIDX_W-1:0]         valid_len,
    output logic [IDX_W-1:0]          rom_idx,
    output logic [EDW_W-1:0]          rom_dw_idx,
    input  logic [BYTE_W-1:0]         rom_bytes,
    input  logic [DW-1:0]             rom_dw,
    output logic                      clr_req,
    output logic                      busy,
    output logic                      wr_en,
    output logic [RIDX_W-1:0]         wr_idx,
    output logic [DW-1:0]             wr_data,
    output logic                      commit,
    output logic [RIDX_W-1:0]         commit_len
);

    bld_state_t       st_q;
    logic [IDX_W-1:0] hdl_q;
    logic [HDL_W-1:0] nxt_q;
    logic [RIDX_W-1:0] base_q;
    logic [RSP_W-1:0] rsp_len_q;
    logic [RSP_W-1:0] k_q;

    logic [LEN_W-1:0] req_len;
    logic [HDL_W-1:0] req_hdl;
    logic [RSP_W-1:0] rsp_len_c;
    logic             cnt_ok, len_ok, hdl_ok, fit_ok, accept;
    logic             last_k;
    logic             req_unused;

    assign req_len    = req_words[1][LEN_W-1:0];
    assign req_hdl    = req_words[2][DW-1:DW-HDL_W];
    assign req_unused = ^{req_words[0], req_words[1][DW-1:LEN_W],
                          req_words[2][DW-HDL_W-1:0]};

    // Request checks made during the CHECK cycle.
    always_comb begin
        cnt_ok    = (req_cnt == CNT_W'(REQ_DW));
        len_ok    = (req_len >= LEN_W'(REQ_DW));
        hdl_ok    = (req_hdl < HDL_W'(NUM_ENT));
        rsp_len_c = RSP_W'(RSP_HDR_DW + dw_ceil(int'(rom_bytes)));
        fit_ok    = (int'(valid_len) + int'(rsp_len_c)) <= RD_DEPTH;
        accept    = cnt_ok && len_ok && hdl_ok && fit_ok;
    end

    // The ROM is addressed by the incoming handle while checking,
    // and by the latched handle while emitting.
    always_comb begin
        rom_idx    = (st_q == B_CHECK) ? req_hdl[IDX_W-1:0] : hdl_q;
        rom_dw_idx = (k_q >= RSP_W'(RSP_HDR_DW)) ?
                     EDW_W'(k_q - RSP_W'(RSP_HDR_DW)) : '0;
    end

    assign last_k  = (k_q == rsp_len_q - 1'b1);
    assign clr_req = (st_q == B_CHECK);
    assign busy    = (st_q != B_IDLE);

    // Sequencer: idle -> check -> emit one dword per cycle -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= B_IDLE;
            hdl_q     <= '0;
            nxt_q     <= '0;
            base_q    <= '0;
            rsp_len_q <= '0;
            k_q       <= '0;
        end else begin
            unique case (st_q)
                B_IDLE: begin
                    if (go) st_q <= B_CHECK;
                end
                B_CHECK: begin
                    if (accept) begin
                        st_q      <= B_EMIT;
                        hdl_q     <= req_hdl[IDX_W-1:0];
                        nxt_q     <= (req_hdl == HDL_W'(NUM_ENT - 1)) ?
                                     HDL_END : req_hdl + 1'b1;
                        base_q    <= valid_len;
                        rsp_len_q <= rsp_len_c;
                        k_q       <= '0;
                    end else begin
                        st_q <= B_IDLE;
                    end
                end
                B_EMIT: begin
                    k_q <= k_q + 1'b1;
                    if (last_k) st_q <= B_IDLE;
                end
                default: st_q <= B_IDLE;
            endcase
        end
    end

    // Response word selected by the emit position.
    always_comb begin
        if (k_q == RSP_W'(0)) begin
            wr_data = {8'h00, OBJ_TYPE, VENDOR_ID};
        end else if (k_q == RSP_W'(1)) begin
            wr_data = {{(DW-LEN_W){1'b0}}, LEN_W'(rsp_len_q)};
        end else if (k_q == RSP_W'(2)) begin
            wr_data = {nxt_q, TBL_TYPE, RSP_CODE};
        end else begin
            wr_data = rom_dw;
        end
    end

    // Write strobe, target slot and commit of the grown length.
    always_comb begin
        wr_en      = (st_q == B_EMIT);
        wr_idx     = base_q + RIDX_W'(k_q);
        commit     = (st_q == B_EMIT) && last_k;
        commit_len = base_q + RIDX_W'(rsp_len_q);
    end

    // R1: a request with a short length field goes straight back to idle.
    p_short_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == B_CHECK && req_len < LEN_W'(REQ_DW)) |=> (st_q == B_IDLE));

    // R8: an out-of-range handle goes straight back to idle.
    p_bad_hdl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == B_CHECK && req_hdl >= HDL_W'(NUM_ENT)) |=> (st_q == B_IDLE));

    // R11: every emitted dword lands inside the read mailbox.
    p_emit_inside_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < RD_DEPTH));

endmodule

// File: rtl/doe_rsp_mbox.sv
// Response read mailbox: a linear store of RD_DEPTH dwords with a read
// index and a readable length. The builder writes above the readable
// length and commits a longer length. Readers pop from the read index.
// When the mailbox is empty and no build is running, both indices
// return to zero.
// Assumes commit_len never exceeds RD_DEPTH.
module doe_rsp_mbox
    import doe_tbl_pkg::*;
#(
    parameter int RD_DEPTH = 16,
    parameter int RIDX_W   = 5,
    parameter int AW       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              commit,
    input  logic [RIDX_W-1:0] commit_len,
    input  logic              bld_busy,
    input  logic              adv,
    output logic [DW-1:0]     rd_data,
    output logic              ready,
    output logic [RIDX_W-1:0] valid_len
);

    logic [DW-1:0]     mem [RD_DEPTH];
    logic [RIDX_W-1:0] rd_idx;
    logic              idx_unused;

    assign idx_unused = ^{wr_idx[RIDX_W-1:AW], rd_idx[RIDX_W-1:AW]};

    // Storage: cleared on reset, written by the builder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RD_DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx[AW-1:0]] <= wr_data;
        end
    end

    // Pointers: pop on advance, grow on commit, rewind when idle and empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx    <= '0;
            valid_len <= '0;
        end else begin
            if (commit) valid_len <= commit_len;
            if (ready && adv) begin
                rd_idx <= rd_idx + 1'b1;
            end else if (!bld_busy && rd_idx == valid_len) begin
                rd_idx    <= '0;
                valid_len <= '0;
            end
        end
    end

    assign ready   = (rd_idx != valid_len);
    assign rd_data = ready ? mem[rd_idx[AW-1:0]] : '0;

    // R11: the readable length never passes the mailbox depth.
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(valid_len) <= RD_DEPTH);

    // R6: popping the last unread dword drops the ready flag.
    p_ready_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && adv && (rd_idx + 1'b1 == valid_len) && !commit) |=> !ready);

    // R7: a committed response is readable on the next cycle.
    p_commit_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ready);

endmodule

// File: rtl/doe_table_responder.sv
// Top level of the table-access mailbox responder. It wires the request
// mailbox, the response builder, the entry ROM and the response
// mailbox together. It also gives the mailbox registers precedence over
// the default word on configuration reads.
// Assumes NUM_ENT >= 2 and a power-of-two RD_DEPTH that holds the
// largest response.
module doe_table_responder
    import doe_tbl_pkg::*;
#(
    parameter int          NUM_ENT      = 4,
    parameter int          LEN_BASE     = 3,
    parameter int          LEN_STEP     = 5,
    parameter int          RD_DEPTH     = 16,
    parameter int          CFG_AW       = 12,
    parameter logic [11:0] RSP_REG_OFS  = 12'h18C,
    parameter logic [11:0] STAT_REG_OFS = 12'h184,
    parameter logic [15:0] VENDOR_ID    = 16'h1D2E,
    parameter logic [7:0]  OBJ_TYPE     = 8'h02,
    parameter logic [7:0]  RSP_CODE     = 8'h81,
    parameter logic [7:0]  TBL_TYPE     = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr_en,
    input  logic [31:0]       req_wr_data,
    input  logic              req_go,
    input  logic              rsp_rd_adv,
    output logic [31:0]       rsp_rd_data,
    output logic              rsp_ready,
    input  logic [CFG_AW-1:0] cfg_rd_addr,
    input  logic [31:0]       cfg_dflt_data,
    output logic [31:0]       cfg_rd_data
);

    localparam int IDX_W      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam int MAX_BYTES  = LEN_BASE + LEN_STEP * (NUM_ENT - 1);
    localparam int BYTE_W     = $clog2(MAX_BYTES + 1);
    localparam int MAX_EDW    = dw_ceil(MAX_BYTES);
    localparam int EDW_W      = $clog2(MAX_EDW + 1);
    localparam int MAX_RSP_DW = RSP_HDR_DW + MAX_EDW;
    localparam int RSP_W      = $clog2(MAX_RSP_DW + 1);
    localparam int RIDX_W     = $clog2(RD_DEPTH + 1);
    localparam int AW         = $clog2(RD_DEPTH);
    localparam int CNT_W      = $clog2(REQ_DW + 1);

    logic [REQ_DW-1:0][DW-1:0] req_words;
    logic [CNT_W-1:0]          req_cnt;
    logic                      clr_req, busy;
    logic [IDX_W-1:0]          rom_idx;
    logic [EDW_W-1:0]          rom_dw_idx;
    logic [BYTE_W-1:0]         rom_bytes;
    logic [DW-1:0]             rom_dw;
    logic                      wr_en, commit;
    logic [RIDX_W-1:0]         wr_idx, commit_len, valid_len;
    logic [DW-1:0]             wr_data;

    doe_req_mbox #(
        .CNT_W (CNT_W)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (req_wr_en),
        .wr_data (req_wr_data),
        .clr     (clr_req),
        .words   (req_words),
        .cnt     (req_cnt)
    );

    doe_entry_rom #(
        .NUM_ENT  (NUM_ENT),
        .LEN_BASE (LEN_BASE),
        .LEN_STEP (LEN_STEP),
        .IDX_W    (IDX_W),
        .EDW_W    (EDW_W),
        .BYTE_W   (BYTE_W)
    ) u_rom (
        .ent_idx   (rom_idx),
        .dw_idx    (rom_dw_idx),
        .ent_bytes (rom_bytes),
        .ent_dw    (rom_dw)
    );

    doe_rsp_builder #(
        .NUM_ENT   (NUM_ENT),
        .RD_DEPTH  (RD_DEPTH),
        .VENDOR_ID (VENDOR_ID),
        .OBJ_TYPE  (OBJ_TYPE),
        .RSP_CODE  (RSP_CODE),
        .TBL_TYPE  (TBL_TYPE),
        .IDX_W     (IDX_W),
        .EDW_W     (EDW_W),
        .BYTE_W    (BYTE_W),
        .RSP_W     (RSP_W),
        .RIDX_W    (RIDX_W),
        .CNT_W     (CNT_W)
    ) u_bld (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (req_go),
        .req_words  (req_words),
        .req_cnt    (req_cnt),
        .valid_len  (valid_len),
        .rom_idx    (rom_idx),
        .rom_dw_idx (rom_dw_idx),
        .rom_bytes  (rom_bytes),
        .rom_dw     (rom_dw),
        .clr_req    (clr_req),
        .busy       (busy),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .commit     (commit),
        .commit_len (commit_len)
    );

    doe_rsp_mbox #(
        .RD_DEPTH (RD_DEPTH),
        .RIDX_W   (RIDX_W),
        .AW       (AW)
    ) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .commit     (commit),
        .commit_len (commit_len),
        .bld_busy   (busy),
        .adv        (rsp_rd_adv),
        .rd_data    (rsp_rd_data),
        .ready      (rsp_ready),
        .valid_len  (valid_len)
    );

    // Configuration read: mailbox registers win over the default word.
    always_comb begin
        if (cfg_rd_addr == CFG_AW'(RSP_REG_OFS)) begin
            cfg_rd_data = rsp_rd_data;
        end else if (cfg_rd_addr == CFG_AW'(STAT_REG_OFS)) begin
            cfg_rd_data = {rsp_ready, 31'b0};
        end else begin
            cfg_rd_data = cfg_dflt_data;
        end
    end

endmodule

// File: tb/doe_table_responder_test.sv
`timescale 1ns/1ps
module doe_table_responder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_wr_en = 1'b0;
    logic [31:0] req_wr_data = '0;
    logic        req_go = 1'b0;
    logic        rsp_rd_adv = 1'b0;
    logic [31:0] rsp_rd_data;
    logic        rsp_ready;
    logic [11:0] cfg_rd_addr = 12'h000;
    logic [31:0] cfg_dflt_data = 32'h0;
    logic [31:0] cfg_rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    doe_table_responder uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_wr_en     (req_wr_en),
        .req_wr_data   (req_wr_data),
        .req_go        (req_go),
        .rsp_rd_adv    (rsp_rd_adv),
        .rsp_rd_data   (rsp_rd_data),
        .rsp_ready     (rsp_ready),
        .cfg_rd_addr   (cfg_rd_addr),
        .cfg_dflt_data (cfg_dflt_data),
        .cfg_rd_data   (cfg_rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ent_len(input int h);
        return 3 + 5 * h;
    endfunction

    function automatic int rsp_dws(input int h);
        return 3 + (ent_len(h) + 3) / 4;
    endfunction

    // Expected response dword k for entry h, from the requirements.
    function automatic logic [31:0] exp_dw(input int h, input int k);
        logic [31:0] w;
        w = '0;
        if (k == 0) w = {8'h00, 8'h02, 16'h1D2E};
        else if (k == 1) w = 32'(rsp_dws(h));
        else if (k == 2) w = {(h == 3) ? 16'hFFFF : 16'(h + 1), 8'h05, 8'h81};
        else begin
            for (int b = 0; b < 4; b++) begin
                int p;
                p = 4 * (k - 3) + b;
                if (p < ent_len(h)) w[8*b +: 8] = 8'(32 * h + p + 1);
            end
        end
        return w;
    endfunction

    task automatic push(input logic [31:0] d);
        @(negedge clk);
        req_wr_en   = 1'b1;
        req_wr_data = d;
        @(negedge clk);
        req_wr_en   = 1'b0;
    endtask

    task automatic go_wait();
        @(negedge clk);
        req_go = 1'b1;
        @(negedge clk);
        req_go = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    task automatic send_req(input logic [17:0] len, input logic [15:0] hdl);
        push({8'h00, 8'h02, 16'h1D2E});
        push({14'b0, len});
        push({hdl, 8'h05, 8'h00});
        go_wait();
    endtask

    // Pop one response for entry h and check each dword; caller is at a negedge.
    task automatic pop_rsp(input int h, input string tag);
        for (int k = 0; k < rsp_dws(h); k++) begin
            chk({tag, " ready"}, 32'(rsp_ready), 32'd1);
            chk($sformatf("%s dw%0d", tag, k), rsp_rd_data, exp_dw(h, k));
            rsp_rd_adv = 1'b1;
            @(negedge clk);
            rsp_rd_adv = 1'b0;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", 32'(rsp_ready), 32'd0);
        chk("R10 data after reset", rsp_rd_data, 32'd0);
        cfg_rd_addr = 12'h184;
        #0.1;
        chk("R10 status after reset", cfg_rd_data, 32'd0);
    endtask

    // R2 R3 R4 R5 R6: a clean request for each entry.
    task automatic t_entry(input int h);
        send_req(18'd3, 16'(h));
        pop_rsp(h, $sformatf("R2-5 entry%0d R6", h));
        chk("R6 ready drops after last dword", 32'(rsp_ready), 32'd0);
        chk("R6 data zero when empty", rsp_rd_data, 32'd0);
    endtask

    task automatic t_short_len();
        send_req(18'd2, 16'd0);
        chk("R1 short length dropped", 32'(rsp_ready), 32'd0);
        send_req(18'd0, 16'd1);
        chk("R1 zero length dropped", 32'(rsp_ready), 32'd0);
    endtask

    task automatic t_bad_handle();
        send_req(18'd3, 16'd4);
        chk("R8 handle 4 dropped", 32'(rsp_ready), 32'd0);
        send_req(18'd3, 16'h1234);
        chk("R8 handle 0x1234 dropped", 32'(rsp_ready), 32'd0);
    endtask

    task automatic t_partial();
        push({8'h00, 8'h02, 16'h1D2E});
        push({14'b0, 18'd3});
        go_wait();
        chk("R8 two-dword request dropped", 32'(rsp_ready), 32'd0);
        // The go strobe emptied the write mailbox: a fresh request parses cleanly.
        send_req(18'd3, 16'd2);
        pop_rsp(2, "R8 request after partial");
        chk("R8 mailbox drained", 32'(rsp_ready), 32'd0);
    endtask

    task automatic t_append();
        send_req(18'd3, 16'd0);
        send_req(18'd4, 16'd1);
        pop_rsp(0, "R7 first of two");
        pop_rsp(1, "R7 appended second");
        chk("R7 empty after both", 32'(rsp_ready), 32'd0);
    endtask

    task automatic t_overflow();
        send_req(18'd3, 16'd3);
        send_req(18'd3, 16'd3);
        send_req(18'd3, 16'd3);
        pop_rsp(3, "R11 copy 1");
        pop_rsp(3, "R11 copy 2");
        chk("R11 third response dropped", 32'(rsp_ready), 32'd0);
    endtask

    task automatic t_cfg();
        send_req(18'd3, 16'd1);
        cfg_dflt_data = 32'hCAFE_F00D;
        cfg_rd_addr   = 12'h18C;
        #0.1;
        chk("R9 mailbox data register", cfg_rd_data, exp_dw(1, 0));
        cfg_rd_addr = 12'h184;
        #0.1;
        chk("R9 status register ready", cfg_rd_data, 32'h8000_0000);
        cfg_rd_addr = 12'h010;
        #0.1;
        chk("R9 default path", cfg_rd_data, 32'hCAFE_F00D);
        @(negedge clk);
        pop_rsp(1, "R9 drain");
        cfg_rd_addr = 12'h184;
        #0.1;
        chk("R9 status register empty", cfg_rd_data, 32'd0);
        cfg_rd_addr = 12'h18C;
        #0.1;
        chk("R9 mailbox data when empty", cfg_rd_data, 32'd0);
    endtask

    task automatic t_mid_reset();
        send_req(18'd3, 16'd2);
        push({8'h00, 8'h02, 16'h1D2E});
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset clears pending response", 32'(rsp_ready), 32'd0);
        chk("R10 reset clears read data", rsp_rd_data, 32'd0);
        send_req(18'd3, 16'd0);
        pop_rsp(0, "R10 request after reset");
    endtask

    initial begin
        t_reset();
        for (int h = 0; h < 4; h++) t_entry(h);
        t_short_len();
        t_bad_handle();
        t_partial();
        t_append();
        t_overflow();
        t_cfg();
        t_mid_reset();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule